// File: doc/BRIEF.md
# Parity Watermark Bit Extractor

This block recovers one hidden bit from a marked DC coefficient of a transformed image block. The coefficient is divided by the quality factor used during embedding. The quotient is then rounded to the nearest integer, with a tie rounded upward. The least significant bit of the rounded quotient is the recovered bit: an even result reads as 0 and an odd result reads as 1.

The division is done one quotient bit per cycle by restoring subtraction. Rounding comes from the final remainder: one adder and one comparator check whether twice the remainder reaches the factor. A caller pulses `start_i` with the operands and waits for the one-cycle `done_o` pulse, which carries the bit on `bit_o`.

Top module: `wm_parity_extract`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0 and `bit_o` is 0.
- R2: A `start_i` sampled high while `busy_o` is low captures `coef_i` (16-bit unsigned) and `factor_i` (6-bit unsigned, used in the range 15 to 35), and raises `busy_o` at that same edge.
- R3: `done_o` rises exactly 17 clock edges after the capturing edge. It stays high for exactly one cycle, and `busy_o` falls at the same edge.
- R4: The quotient is `coef / factor` with remainder `coef % factor`. The rounded quotient is the quotient plus 1 when twice the remainder is greater than or equal to the factor, and the quotient alone otherwise, so an exact half rounds up.
- R5: `bit_o` equals bit 0 of the rounded quotient (even gives 0, odd gives 1). It is updated only at the edge where `done_o` rises and holds its value until the next result.
- R6: While `busy_o` is high, `start_i` and any change of `coef_i` or `factor_i` have no effect: the pending result, its timing and its value are unchanged, and no extra `done_o` pulse follows.
- R7: The remainder held during the division is always smaller than the captured factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one extraction |
| coef_i | input | 16 | Marked DC coefficient, unsigned |
| factor_i | input | 6 | Quality factor |
| busy_o | output | 1 | Extraction in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| bit_o | output | 1 | Recovered watermark bit |

## Verification
Counted from the rising edge that samples `start_i`, `busy_o` is high after that same edge. `done_o` and the new `bit_o` are due after the seventeenth following edge, and `done_o` must be low again one edge later. The bench drives inputs on falling edges and counts falling edges from the start pulse. It checks that `done_o` stays low at the first seventeen, then samples `done_o` and `bit_o` at the eighteenth and confirms the pulse has ended at the nineteenth. Its table covers exact, just-below-half, exact-half and above-half remainders at both ends of the factor range. A second start and operand changes are injected mid-division, and the original result and timing are still expected.

// File: rtl/wm_parity_extract.sv
module wm_parity_extract #(
  parameter int W  = 16,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [W-1:0]  coef_i,
  input  logic [FW-1:0] factor_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          bit_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic [CW-1:0] cnt;
  logic [W-1:0]  quo;
  logic [FW-1:0] rem;
  logic [FW-1:0] div;

  logic [FW:0] trial, diff;
  logic        take, round_up;
  logic [W-1:0] rounded;

  assign trial    = {rem, quo[W-1]};
  assign diff     = trial - {1'b0, div};
  assign take     = trial >= {1'b0, div};
  assign round_up = {rem, 1'b0} >= {1'b0, div};
  assign rounded  = quo + W'(round_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      bit_o  <= 1'b0;
      cnt    <= '0;
      quo    <= '0;
      rem    <= '0;
      div    <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          cnt    <= '0;
          quo    <= coef_i;
          rem    <= '0;
          div    <= factor_i;
        end
      end else if (cnt == LAST) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        bit_o  <= rounded[0];
      end else begin
        cnt <= cnt + 1'b1;
        quo <= {quo[W-2:0], take};
        rem <= take ? diff[FW-1:0] : trial[FW-1:0];
      end
    end
  end

  AST_START_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R3
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> ($stable(bit_o) || done_o)); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && cnt != LAST) |=> (busy_o && $stable(div))); // R6
  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (rem < div)); // R7
endmodule

// File: tb/tb_wm_parity_extract.sv
module tb_wm_parity_extract;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] coef_i = '0;
  logic [5:0]  factor_i = '0;
  logic        busy_o, done_o, bit_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wm_parity_extract dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .coef_i(coef_i),
    .factor_i(factor_i), .busy_o(busy_o), .done_o(done_o), .bit_o(bit_o)
  );

  // {coefficient, factor, expected bit}
  localparam logic [22:0] VEC [12] = '{
    {16'd0,     6'd15, 1'b0},
    {16'd65535, 6'd15, 1'b1},
    {16'd37,    6'd25, 1'b1},
    {16'd38,    6'd25, 1'b0},
    {16'd50,    6'd20, 1'b1},
    {16'd30,    6'd20, 1'b0},
    {16'd1000,  6'd35, 1'b1},
    {16'd65535, 6'd35, 1'b0},
    {16'd17,    6'd35, 1'b0},
    {16'd18,    6'd35, 1'b1},
    {16'd12345, 6'd16, 1'b0},
    {16'd4096,  6'd32, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Pulses start, optionally injects a second start and new operands mid-run,
  // then checks timing (R3) and the recovered bit (R4, R5).
  task automatic run(input logic [15:0] c, input logic [5:0] f,
                     input logic exp, input bit disturb);
    logic early;
    @(negedge clk);
    start_i = 1'b1; coef_i = c; factor_i = f;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after capture", busy_o, 1'b1);
    early = done_o;
    for (int k = 2; k <= 17; k++) begin
      if (disturb && k == 5) begin
        start_i = 1'b1; coef_i = 16'd50; factor_i = 6'd20;
      end
      if (disturb && k == 6) start_i = 1'b0;
      @(negedge clk);
      early = early | done_o;
    end
    check("R3 no early done", early, 1'b0);
    @(negedge clk);
    check("R3 done after 17 edges", done_o, 1'b1);
    check("R3 busy falls with done", busy_o, 1'b0);
    check(disturb ? "R6 result unchanged" : "R4 R5 bit value", bit_o, exp);
    @(negedge clk);
    check("R3 done lasts one cycle", done_o, 1'b0);
    check("R5 bit held", bit_o, exp);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #5;
    check("R1 busy at reset", busy_o, 1'b0);
    check("R1 done at reset", done_o, 1'b0);
    check("R1 bit at reset", bit_o, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", busy_o, 1'b0);

    foreach (VEC[i]) run(VEC[i][22:7], VEC[i][6:1], VEC[i][0], 1'b0);

    // R6: 37/25 gives 1; injected 50/20 would also give 1, so use an even case
    run(16'd38, 6'd25, 1'b0, 1'b1);
    // R6: no second done pulse from the ignored start
    begin
      logic extra = 1'b0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        extra = extra | done_o;
      end
      check("R6 no extra done", extra, 1'b0);
      check("R6 idle after ignored start", busy_o, 1'b0);
    end

    // R5: bit toggles between back-to-back results
    run(16'd65535, 6'd15, 1'b1, 1'b0);
    run(16'd0, 6'd15, 1'b0, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule